// File: doc/BRIEF.md
# Command/Indicate Channel Debounced Transceiver

This block carries the Command/Indicate (C/I) field of a time-division frame link in both directions. Once per frame a strobe marks the point where the incoming C/I slot value is valid. The block keeps the value seen on the previous frame and compares each new sample with it. A code is taken as the new accepted value only when two consecutive frames carry the same code and that code differs from the accepted value. When a code is accepted, a sticky change interrupt is raised.

In the other direction, the processor may write a transmit code at any moment. That code goes into a shadow register and is copied to the outgoing slot value only at a frame strobe, so the outgoing code never changes part-way through a frame. The outgoing code is driven on every frame. The code width is a parameter: 4 bits suits the layer-1 link and 6 bits suits the local peripheral link. The all-ones code means deactivate/idle. The all-zeros code is the timing-request command, and the block treats it like any other code. Serial shifting and frame clocking are handled outside the block.

Top module: `ciXcvr`

## Requirements
- R1: After reset, `acceptedCode` and `txCode` are all ones (idle) and `changeIrq` is 0.
- R2: When `frameStrobe` is high on two consecutive frames with the same `rxCode`, and that code differs from `acceptedCode`, then `acceptedCode` takes that code in the cycle after the second strobe. The history register starts at all ones, so a non-idle code needs two frames after reset before it is accepted.
- R3: A code that appears on only one frame, with a different code on the next frame, is never accepted.
- R4: A code equal to the current `acceptedCode` never raises `changeIrq`, however many frames it stays stable.
- R5: `changeIrq` goes to 1 in the cycle after an acceptance. It stays 1 until a cycle with `irqClr` high, after which it reads 0. If an acceptance and `irqClr` fall in the same cycle, the interrupt ends up set.
- R6: `rxCode` has no effect in cycles where `frameStrobe` is low.
- R7: `txWrEn` stores `txWrData` at any cycle. `txCode` changes only in the cycle after a `frameStrobe`, and it then takes the value stored before that edge. A write made in the same cycle as a strobe therefore appears one frame later.
- R8: The idle code (all ones) is accepted like any other code. After some other code has been accepted, two idle frames restore idle and raise `changeIrq`. The all-zeros code is accepted with no special handling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameStrobe | input | 1 | One-cycle pulse: `rxCode` holds this frame's slot value |
| rxCode | input | CODE_W | Incoming C/I slot code |
| txWrEn | input | 1 | Processor write of the transmit code |
| txWrData | input | CODE_W | Transmit code written by the processor |
| irqClr | input | 1 | Write-one-to-clear of the change interrupt |
| txCode | output | CODE_W | Outgoing C/I slot code for the current frame |
| acceptedCode | output | CODE_W | Last debounced incoming code |
| changeIrq | output | 1 | Sticky change interrupt |

## Verification
The bench targets single-frame glitches, which a design comparing only against the accepted value would wrongly accept. It also targets stable repeats of the accepted code, which a design missing the inequality test would report as a spurious interrupt. Transmit writes are placed both between strobes and on a strobe cycle. A design without the shadow register would change `txCode` in mid-frame, or pick up the new code one frame early. A clear is issued in the same cycle as an acceptance, so a design that lets the clear win would lose that event. A random run then checks every output against a behavioural model on every cycle.

// File: rtl/ciPkg.sv
package ciPkg;
  // Strobes from the control to the datapath, one cycle wide each.
  typedef struct packed {
    logic sampleEn;  // store this frame's code into the history register
    logic acceptEn;  // copy the incoming code into the accepted register
    logic txLoad;    // move the shadow transmit code to the outgoing slot
  } ciStrobe_t;
endpackage

// File: rtl/ciDatapath.sv
module ciDatapath
  import ciPkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ciStrobe_t         strobes,
  input  logic [CODE_W-1:0] rxCode,
  input  logic              txWrEn,
  input  logic [CODE_W-1:0] txWrData,
  output logic              matchPrev,
  output logic              matchAccepted,
  output logic [CODE_W-1:0] acceptedCode,
  output logic [CODE_W-1:0] txCode
);
  localparam logic [CODE_W-1:0] IDLE_CODE = '1;

  logic [CODE_W-1:0] prevSample;
  logic [CODE_W-1:0] acceptedQ;
  logic [CODE_W-1:0] txShadow;
  logic [CODE_W-1:0] txQ;
  logic [CODE_W-1:0] diffPrev;
  logic [CODE_W-1:0] diffAcc;

  // Compare each bit of the incoming code separately, then reduce.
  for (genvar b = 0; b < CODE_W; b++) begin : gBitCmp
    assign diffPrev[b] = rxCode[b] ^ prevSample[b];
    assign diffAcc[b]  = rxCode[b] ^ acceptedQ[b];
  end

  assign matchPrev     = ~|diffPrev;
  assign matchAccepted = ~|diffAcc;

  // Receive side: history register and accepted register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSample <= IDLE_CODE;
      acceptedQ  <= IDLE_CODE;
    end else begin
      if (strobes.sampleEn) prevSample <= rxCode;
      if (strobes.acceptEn) acceptedQ  <= rxCode;
    end
  end

  // Transmit side: the shadow takes writes at any cycle, the slot value
  // moves only on a frame boundary.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShadow <= IDLE_CODE;
      txQ      <= IDLE_CODE;
    end else begin
      if (strobes.txLoad) txQ <= txShadow;
      if (txWrEn) txShadow <= txWrData;
    end
  end

  assign acceptedCode = acceptedQ;
  assign txCode       = txQ;

  AST_ACCEPT_TWO_FRAMES: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(acceptedQ) |-> ($past(rxCode) == $past(prevSample)) && (acceptedQ == $past(rxCode))); // R2
  AST_ACCEPT_IS_NEW: assert property (@(posedge clk) disable iff (!rstN)
    strobes.acceptEn |-> (rxCode != acceptedQ)); // R4
  AST_TX_FRAME_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txQ) |-> $past(strobes.txLoad)); // R7
endmodule

// File: rtl/ciControl.sv
module ciControl
  import ciPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameStrobe,
  input  logic      matchPrev,
  input  logic      matchAccepted,
  input  logic      irqClr,
  output ciStrobe_t strobes,
  output logic      changeIrq
);
  logic irqSet;
  logic irqQ;

  // Accept only on a strobe, when the sample repeats and is new.
  assign irqSet = frameStrobe & matchPrev & ~matchAccepted;

  always_comb begin
    strobes          = '0;
    strobes.sampleEn = frameStrobe;
    strobes.acceptEn = irqSet;
    strobes.txLoad   = frameStrobe;
  end

  // Sticky status: setting has priority over a clear in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       irqQ <= 1'b0;
    else if (irqSet) irqQ <= 1'b1;
    else if (irqClr) irqQ <= 1'b0;
  end

  assign changeIrq = irqQ;

  AST_IRQ_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    strobes.acceptEn |=> changeIrq); // R5
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    changeIrq && !irqClr |=> changeIrq); // R5
  AST_IRQ_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    $rose(changeIrq) |-> $past(frameStrobe)); // R6
  AST_STROBES_ONLY_ON_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    !frameStrobe |-> !strobes.acceptEn && !strobes.txLoad); // R6
endmodule

// File: rtl/ciXcvr.sv
module ciXcvr
  import ciPkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStrobe,
  input  logic [CODE_W-1:0] rxCode,
  input  logic              txWrEn,
  input  logic [CODE_W-1:0] txWrData,
  input  logic              irqClr,
  output logic [CODE_W-1:0] txCode,
  output logic [CODE_W-1:0] acceptedCode,
  output logic              changeIrq
);
  ciStrobe_t strobes;
  logic      matchPrev;
  logic      matchAccepted;

  ciControl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .frameStrobe  (frameStrobe),
    .matchPrev    (matchPrev),
    .matchAccepted(matchAccepted),
    .irqClr       (irqClr),
    .strobes      (strobes),
    .changeIrq    (changeIrq)
  );

  ciDatapath #(.CODE_W(CODE_W)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .rxCode       (rxCode),
    .txWrEn       (txWrEn),
    .txWrData     (txWrData),
    .matchPrev    (matchPrev),
    .matchAccepted(matchAccepted),
    .acceptedCode (acceptedCode),
    .txCode       (txCode)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    $rose(rstN) |-> (acceptedCode == '1) && (txCode == '1) && !changeIrq); // R1
endmodule

// File: tb/sim_ciXcvr.sv
module sim_ciXcvr;
  localparam int W = 4;
  localparam int IDLE = (1 << W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameStrobe = 1'b0;
  logic [W-1:0] rxCode = '0;
  logic txWrEn = 1'b0;
  logic [W-1:0] txWrData = '0;
  logic irqClr = 1'b0;
  logic [W-1:0] txCode;
  logic [W-1:0] acceptedCode;
  logic changeIrq;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // Behavioural reference state.
  int mPrev = IDLE;
  int mAcc = IDLE;
  int mShadow = IDLE;
  int mTx = IDLE;
  int mIrq = 0;

  always #4 clk = ~clk;

  ciXcvr #(.CODE_W(W)) u0 (
    .clk(clk), .rstN(rstN), .frameStrobe(frameStrobe), .rxCode(rxCode),
    .txWrEn(txWrEn), .txWrData(txWrData), .irqClr(irqClr),
    .txCode(txCode), .acceptedCode(acceptedCode), .changeIrq(changeIrq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: update the model with pre-edge inputs, then compare.
  task automatic step();
    bit setNow;
    @(posedge clk);
    setNow = 1'b0;
    if (rstN) begin
      if (frameStrobe) begin
        if (int'(rxCode) == mPrev && int'(rxCode) != mAcc) begin
          mAcc = rxCode;
          setNow = 1'b1;
        end
        mPrev = rxCode;
        mTx = mShadow;
      end
      if (txWrEn) mShadow = txWrData;
      if (setNow) mIrq = 1;
      else if (irqClr) mIrq = 0;
    end
    @(negedge clk);
    if (rstN) begin
      check(int'(acceptedCode) == mAcc, "R2 model acceptedCode", acceptedCode, mAcc);
      check(int'(txCode) == mTx, "R7 model txCode", txCode, mTx);
      check(int'(changeIrq) == mIrq, "R5 model changeIrq", changeIrq, mIrq);
    end
  endtask

  // One frame: strobe cycle, then two idle cycles carrying noise on rxCode.
  task automatic frame(input int code);
    frameStrobe = 1'b1;
    rxCode = code[W-1:0];
    step();
    frameStrobe = 1'b0;
    rxCode = ~code[W-1:0];
    step();
    step();
  endtask

  task automatic clearIrq();
    irqClr = 1'b1;
    step();
    irqClr = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(acceptedCode == '1, "R1 reset acceptedCode", acceptedCode, IDLE);
    check(txCode == '1, "R1 reset txCode", txCode, IDLE);
    check(changeIrq == 1'b0, "R1 reset changeIrq", changeIrq, 0);
    rstN = 1'b1;
    step();

    // R2: one frame is not enough, two frames are.
    frame(5);
    check(acceptedCode == 4'd15, "R2 single frame not accepted", acceptedCode, 15);
    frame(5);
    check(acceptedCode == 4'd5, "R2 two frames accepted", acceptedCode, 5);
    check(changeIrq == 1'b1, "R5 irq raised on accept", changeIrq, 1);
    step(); step();
    check(changeIrq == 1'b1, "R5 irq sticky", changeIrq, 1);
    clearIrq();
    check(changeIrq == 1'b0, "R5 irq cleared", changeIrq, 0);

    // R4: stable repeat of accepted code.
    frame(5); frame(5); frame(5);
    check(changeIrq == 1'b0, "R4 no irq on accepted repeat", changeIrq, 0);

    // R3: glitch codes.
    frame(3); frame(9); frame(3); frame(5);
    check(acceptedCode == 4'd5, "R3 glitch rejected", acceptedCode, 5);
    check(changeIrq == 1'b0, "R3 no irq on glitch", changeIrq, 0);

    // R6: rxCode without strobe, held stable for many cycles.
    rxCode = 4'd10;
    repeat (6) step();
    check(acceptedCode == 4'd5, "R6 no-strobe rxCode ignored", acceptedCode, 5);
    check(changeIrq == 1'b0, "R6 no-strobe no irq", changeIrq, 0);

    // R7: write between frames, visible only after the next strobe.
    txWrEn = 1'b1; txWrData = 4'd0; step(); txWrEn = 1'b0;
    step();
    check(txCode == 4'd15, "R7 tx unchanged mid-frame", txCode, 15);
    frame(5);
    check(txCode == 4'd0, "R7 tx loaded at frame", txCode, 0);
    // Write on the strobe cycle: appears one frame later.
    frameStrobe = 1'b1; rxCode = 4'd5; txWrEn = 1'b1; txWrData = 4'd6;
    step();
    frameStrobe = 1'b0; txWrEn = 1'b0;
    check(txCode == 4'd0, "R7 same-cycle write deferred", txCode, 0);
    step();
    frame(5);
    check(txCode == 4'd6, "R7 deferred write applied", txCode, 6);

    // R5: accept and clear in the same cycle -> set wins.
    frame(0);
    frameStrobe = 1'b1; rxCode = 4'd0; irqClr = 1'b1;
    step();
    frameStrobe = 1'b0; irqClr = 1'b0;
    check(acceptedCode == 4'd0, "R8 zero code accepted", acceptedCode, 0);
    check(changeIrq == 1'b1, "R5 set beats clear", changeIrq, 1);
    clearIrq();

    // R8: return to idle.
    frame(15); frame(15);
    check(acceptedCode == 4'd15, "R8 idle re-accepted", acceptedCode, 15);
    check(changeIrq == 1'b1, "R8 idle raises irq", changeIrq, 1);
    clearIrq();

    // Random run against the model.
    for (int i = 0; i < 400; i++) begin
      int pick;
      pick = $urandom_range(0, 3);
      frameStrobe = 1'b1;
      rxCode = (pick == 0) ? 4'd15 : (pick == 1) ? 4'd0 : (pick == 2) ? 4'd5 : 4'($urandom_range(0, 15));
      txWrEn = ($urandom_range(0, 3) == 0);
      txWrData = 4'($urandom_range(0, 15));
      irqClr = ($urandom_range(0, 3) == 0);
      step();
      frameStrobe = 1'b0;
      rxCode = 4'($urandom_range(0, 15));
      txWrEn = ($urandom_range(0, 2) == 0);
      txWrData = 4'($urandom_range(0, 15));
      irqClr = ($urandom_range(0, 5) == 0);
      step();
      txWrEn = 1'b0;
      irqClr = 1'b0;
      step();
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule